// File: doc/BRIEF.md
# Bridge Transaction Forwarding Decoder

This block decides, for every transaction that appears on either side of a two-port PCI-to-PCI bridge, whether the bridge should claim it and pass it across. Each transaction arrives with an address, a command code and the side it started on. The block compares the address against three programmable windows: an I/O window, a non-prefetchable memory window and a prefetchable memory window. Decoding is inverse by side. A primary-side transaction is sent downstream when it hits a window. A secondary-side transaction is sent upstream when it misses the windows.

Legacy ISA aliasing can take the upper 768 bytes of every 1KB block below 64KB out of the downstream I/O space. A separate enable gates each direction. A prefetch flag tells the data path whether it may read ahead or must stop after one data phase. The block is programmed through a small write-only register port. Its decision is registered and appears one clock after the address strobe.

Top module: `pci_fwd_decoder`

## Requirements
- R1: `dec_valid` is high in exactly the cycle that follows a cycle with `txn_valid` high. In that cycle `fwd_down`, `fwd_up` and `prefetch_ok` hold the decision for the transaction that was presented. While `dec_valid` is low, all three are low.
- R2: After reset, all outputs are low and all three enables are clear. Every window has base all ones and limit zero, so it matches nothing.
- R3: An I/O address hits the I/O window when bits [31:16] are zero and the inclusive window `base <= addr[15:12] <= limit` holds. A base above the limit disables the window. A primary-side I/O command (code 0 = I/O read, 1 = I/O write) that hits is sent downstream. A secondary-side I/O command is sent upstream only when it does not hit.
- R4: When ISA aliasing is on, an I/O address with bits [31:16] zero and bits [9:8] non-zero is never sent downstream. From the secondary side it is sent upstream even if it lies inside the I/O window. Addresses at or above 64KB are not affected.
- R5: A memory address hits a memory window when the inclusive window `base <= addr[31:20] <= limit` holds, so each window covers whole 1MB blocks. A primary-side memory command (code 2 = read, 3 = read line, 4 = read multiple, 5 = write) that hits the non-prefetchable window is sent downstream. A secondary-side memory command in that window is ignored.
- R6: A memory transaction is sent downstream only while the memory enable is set. I/O downstream forwarding does not depend on this enable.
- R7: Upstream forwarding of both I/O and memory commands happens only while the master enable is set.
- R8: `prefetch_ok` is high only for a forwarded memory read command. It is high for read line and read multiple. A plain read gets it only when it goes downstream through the prefetchable window. Writes, I/O commands and codes 6 and 7 never get it.
- R9: A secondary-side memory address that hits the prefetchable window, or that arrives with `txn_vga_hit` high, is not sent upstream. From the primary side, either condition sends it downstream. `txn_vga_hit` has no effect on I/O commands.
- R10: Command codes 6 and 7 are never forwarded.
- R11: A write to `cfg_sel` 0 loads ISA aliasing (bit 0), memory enable (bit 1) and master enable (bit 2). `cfg_sel` 1 loads the I/O base from bits [3:0] and the I/O limit from bits [19:16]. `cfg_sel` 2 loads the non-prefetchable window and `cfg_sel` 3 loads the prefetchable window: base in bits [11:0], limit in bits [27:16]. The new values are used from the next transaction on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 32 | Configuration write data |
| txn_valid | input | 1 | Transaction address strobe |
| txn_addr | input | 32 | Transaction address |
| txn_cmd | input | 3 | Command code |
| txn_from_sec | input | 1 | 1 = started on secondary side |
| txn_vga_hit | input | 1 | Address claimed by legacy display decode |
| dec_valid | output | 1 | Decision valid |
| fwd_down | output | 1 | Claim on primary, forward downstream |
| fwd_up | output | 1 | Claim on secondary, forward upstream |
| prefetch_ok | output | 1 | Read-ahead permitted |

## Verification
The bench builds the block with its default parameters: a 32-bit address, memory windows at 1MB granularity (bit 20 upward) and a 16-bit I/O space at 4KB granularity. These values let full 32-bit vector addresses reach the exact edges of the windows: the last byte of a 1MB limit block, the first and last bytes of a 4KB I/O window, the 256-byte edges inside a 1KB alias block, and the first address above 64KB. All eight enable combinations are stepped through against fixed windows, and an I/O window with its base above its limit is also checked.

// File: rtl/pci_fwd_pkg.sv
package pci_fwd_pkg;

  localparam logic [2:0] CMD_IO_RD   = 3'd0;
  localparam logic [2:0] CMD_IO_WR   = 3'd1;
  localparam logic [2:0] CMD_MEM_RD  = 3'd2;
  localparam logic [2:0] CMD_MEM_RDL = 3'd3;
  localparam logic [2:0] CMD_MEM_RDM = 3'd4;
  localparam logic [2:0] CMD_MEM_WR  = 3'd5;

  typedef struct packed {
    logic mst_en;
    logic mem_en;
    logic isa_en;
  } ctrl_t;

  function automatic logic cmd_is_io(input logic [2:0] c);
    return (c == CMD_IO_RD) || (c == CMD_IO_WR);
  endfunction

  function automatic logic cmd_is_mem(input logic [2:0] c);
    return (c >= CMD_MEM_RD) && (c <= CMD_MEM_WR);
  endfunction

  function automatic logic cmd_is_mem_read(input logic [2:0] c);
    return (c >= CMD_MEM_RD) && (c <= CMD_MEM_RDM);
  endfunction

  function automatic logic cmd_is_burst_read(input logic [2:0] c);
    return (c == CMD_MEM_RDL) || (c == CMD_MEM_RDM);
  endfunction

endpackage

// File: rtl/pci_fwd_cfg.sv
module pci_fwd_cfg
  import pci_fwd_pkg::*;
#(
  parameter int IO_FLD_W  = 4,
  parameter int MEM_FLD_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_wr,
  input  logic [1:0]               cfg_sel,
  input  logic [31:0]              cfg_wdata,
  output ctrl_t                    ctrl,
  output logic [IO_FLD_W-1:0]      io_base,
  output logic [IO_FLD_W-1:0]      io_limit,
  output logic [1:0][MEM_FLD_W-1:0] mem_base,
  output logic [1:0][MEM_FLD_W-1:0] mem_limit
);
  localparam int HI_LSB = 16;

  logic unused_cfg_bits;
  assign unused_cfg_bits = ^cfg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl     <= '0;
      io_base  <= '1;
      io_limit <= '0;
    end else if (cfg_wr) begin
      if (cfg_sel == 2'd0) ctrl <= cfg_wdata[2:0];
      if (cfg_sel == 2'd1) begin
        io_base  <= cfg_wdata[IO_FLD_W-1:0];
        io_limit <= cfg_wdata[HI_LSB +: IO_FLD_W];
      end
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_mem_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mem_base[w]  <= '1;
        mem_limit[w] <= '0;
      end else if (cfg_wr && (cfg_sel == 2'(w + 2))) begin
        mem_base[w]  <= cfg_wdata[MEM_FLD_W-1:0];
        mem_limit[w] <= cfg_wdata[HI_LSB +: MEM_FLD_W];
      end
    end
  end

  p_ctrl_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == 2'd0) |=> (ctrl == $past(cfg_wdata[2:0])));

endmodule

// File: rtl/pci_fwd_window.sv
module pci_fwd_window #(
  parameter int FLD_W = 12
) (
  input  logic [FLD_W-1:0] base,
  input  logic [FLD_W-1:0] limit,
  input  logic [FLD_W-1:0] field,
  output logic             hit
);
  function automatic logic inside_win(input logic [FLD_W-1:0] b,
                                      input logic [FLD_W-1:0] l,
                                      input logic [FLD_W-1:0] f);
    return (f >= b) && (f <= l);
  endfunction

  assign hit = inside_win(base, limit, field);
endmodule

// File: rtl/pci_fwd_decide.sv
module pci_fwd_decide
  import pci_fwd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IO_SPACE_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        cmd,
  input  logic              from_sec,
  input  logic              vga_hit,
  input  ctrl_t             ctrl,
  input  logic              io_win_hit,
  input  logic              mmio_hit,
  input  logic              pf_hit,
  output logic              isa_alias,
  output logic              dn,
  output logic              up,
  output logic              pf
);
  localparam int ALIAS_LSB = 8;
  localparam int ALIAS_W   = 2;

  logic unused_addr;
  assign unused_addr = ^addr;

  logic low_io, io_claim, mem_claim, is_io, is_mem;

  function automatic logic in_alias(input logic [ALIAS_W-1:0] off_hi);
    return off_hi != '0;
  endfunction

  assign low_io    = (addr[ADDR_W-1:IO_SPACE_W] == '0);
  assign isa_alias = ctrl.isa_en && low_io && in_alias(addr[ALIAS_LSB +: ALIAS_W]);
  assign io_claim  = io_win_hit && low_io && !isa_alias;
  assign mem_claim = mmio_hit || pf_hit || vga_hit;
  assign is_io     = cmd_is_io(cmd);
  assign is_mem    = cmd_is_mem(cmd);

  always_comb begin
    dn = !from_sec && ((is_io && io_claim) || (is_mem && ctrl.mem_en && mem_claim));
    up = from_sec && ctrl.mst_en && ((is_io && !io_claim) || (is_mem && !mem_claim));
    pf = cmd_is_mem_read(cmd) && (dn || up) &&
         (cmd_is_burst_read(cmd) || (!from_sec && pf_hit));
  end
endmodule

// File: rtl/pci_fwd_decoder.sv
module pci_fwd_decoder
  import pci_fwd_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int MEM_LSB    = 20,
  parameter int IO_SPACE_W = 16,
  parameter int IO_LSB     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              txn_valid,
  input  logic [ADDR_W-1:0] txn_addr,
  input  logic [2:0]        txn_cmd,
  input  logic              txn_from_sec,
  input  logic              txn_vga_hit,
  output logic              dec_valid,
  output logic              fwd_down,
  output logic              fwd_up,
  output logic              prefetch_ok
);
  localparam int MEM_FLD_W = ADDR_W - MEM_LSB;
  localparam int IO_FLD_W  = IO_SPACE_W - IO_LSB;

  ctrl_t                      ctrl;
  logic [IO_FLD_W-1:0]        io_base, io_limit;
  logic [1:0][MEM_FLD_W-1:0]  mem_base, mem_limit;
  logic                       io_win_hit;
  logic [1:0]                 mem_hit;   // [0] non-prefetchable, [1] prefetchable
  logic                       isa_alias_c, dn_c, up_c, pf_c;

  pci_fwd_cfg #(.IO_FLD_W(IO_FLD_W), .MEM_FLD_W(MEM_FLD_W)) i_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctrl(ctrl), .io_base(io_base), .io_limit(io_limit),
    .mem_base(mem_base), .mem_limit(mem_limit)
  );

  pci_fwd_window #(.FLD_W(IO_FLD_W)) i_io_win (
    .base(io_base), .limit(io_limit),
    .field(txn_addr[IO_LSB +: IO_FLD_W]), .hit(io_win_hit)
  );

  for (genvar w = 0; w < 2; w++) begin : g_mem_cmp
    pci_fwd_window #(.FLD_W(MEM_FLD_W)) i_mem_win (
      .base(mem_base[w]), .limit(mem_limit[w]),
      .field(txn_addr[MEM_LSB +: MEM_FLD_W]), .hit(mem_hit[w])
    );
  end

  pci_fwd_decide #(.ADDR_W(ADDR_W), .IO_SPACE_W(IO_SPACE_W)) i_decide (
    .addr(txn_addr), .cmd(txn_cmd), .from_sec(txn_from_sec), .vga_hit(txn_vga_hit),
    .ctrl(ctrl), .io_win_hit(io_win_hit), .mmio_hit(mem_hit[0]), .pf_hit(mem_hit[1]),
    .isa_alias(isa_alias_c), .dn(dn_c), .up(up_c), .pf(pf_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid   <= 1'b0;
      fwd_down    <= 1'b0;
      fwd_up      <= 1'b0;
      prefetch_ok <= 1'b0;
    end else begin
      dec_valid   <= txn_valid;
      fwd_down    <= txn_valid && dn_c;
      fwd_up      <= txn_valid && up_c;
      prefetch_ok <= txn_valid && pf_c;
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    txn_valid |=> dec_valid);
  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !(fwd_down || fwd_up || prefetch_ok));
  p_isa_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_valid && cmd_is_io(txn_cmd) && isa_alias_c) |-> !dn_c);
  p_sec_no_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    txn_from_sec |-> !dn_c);
  p_pri_no_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !txn_from_sec |-> !up_c);
  p_mem_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_is_mem(txn_cmd) && !ctrl.mem_en) |-> !dn_c);
  p_mst_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.mst_en |-> !up_c);
  p_pf_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_is_mem_read(txn_cmd) |-> !pf_c);

endmodule

// File: tb/test_pci_fwd_decoder.sv
module test_pci_fwd_decoder;
  localparam logic [2:0] IORD = 3'd0, IOWR = 3'd1, MRD = 3'd2, MRDL = 3'd3,
                         MRDM = 3'd4, MWR = 3'd5, BAD = 3'd6;
  localparam int NV = 27;
  // {from_sec, vga, cmd, addr, exp_down, exp_up, exp_pf}
  localparam logic [39:0] VEC [NV] = '{
    {1'b0,1'b0,IORD,32'h0000_1000,3'b100},  // R3 window bottom
    {1'b0,1'b0,IORD,32'h0000_10FF,3'b100},  // R4 last non-alias byte
    {1'b0,1'b0,IORD,32'h0000_1100,3'b000},  // R4 first alias byte
    {1'b0,1'b0,IOWR,32'h0000_13FF,3'b000},  // R4 last alias byte
    {1'b0,1'b0,IORD,32'h0000_1400,3'b100},  // R4 next 1KB block
    {1'b1,1'b0,IORD,32'h0000_1100,3'b010},  // R4 alias goes up
    {1'b1,1'b0,IORD,32'h0000_1000,3'b000},  // R3 in window ignored
    {1'b1,1'b0,IORD,32'h0000_0FFF,3'b010},  // R3 below window up
    {1'b0,1'b0,IORD,32'h0000_4000,3'b000},  // R3 above limit
    {1'b0,1'b0,IORD,32'h0000_3C00,3'b100},  // R3 last limit block
    {1'b1,1'b0,IOWR,32'h0001_0100,3'b010},  // R4 above 64KB up
    {1'b0,1'b0,IORD,32'h0001_1000,3'b000},  // R3 upper bits nonzero
    {1'b0,1'b0,MRD ,32'h1000_0000,3'b100},  // R8 plain read no pf
    {1'b0,1'b0,MRDL,32'h1FFF_FFFF,3'b101},  // R5 limit inclusive
    {1'b0,1'b0,MRDM,32'h1000_0004,3'b101},  // R8 burst pf
    {1'b0,1'b0,MWR ,32'h2000_0000,3'b000},  // R5 above limit
    {1'b0,1'b0,MRD ,32'h0FFF_FFFF,3'b000},  // R5 below base
    {1'b1,1'b0,MRD ,32'h1000_0000,3'b000},  // R5 sec in window ignored
    {1'b1,1'b0,MRD ,32'h2000_0000,3'b010},  // R8 up plain no pf
    {1'b1,1'b0,MRDL,32'h2000_0000,3'b011},  // R8 up burst pf
    {1'b1,1'b0,MWR ,32'h4000_0000,3'b000},  // R9 pref blocks up
    {1'b0,1'b0,MRD ,32'h4000_0000,3'b101},  // R8 pref plain read pf
    {1'b0,1'b0,MWR ,32'h4FFF_FFFF,3'b100},  // R8 write no pf
    {1'b1,1'b1,MRD ,32'h3000_0000,3'b000},  // R9 vga blocks up
    {1'b0,1'b1,MRD ,32'h3000_0000,3'b100},  // R9 vga down
    {1'b0,1'b0,BAD ,32'h1000_0000,3'b000},  // R10 bad code
    {1'b1,1'b1,IORD,32'h0000_1000,3'b000}   // R9 vga no effect on IO
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0; logic [1:0] cfg_sel = '0; logic [31:0] cfg_wdata = '0;
  logic txn_valid = 1'b0; logic [31:0] txn_addr = '0; logic [2:0] txn_cmd = '0;
  logic txn_from_sec = 1'b0, txn_vga_hit = 1'b0;
  logic dec_valid, fwd_down, fwd_up, prefetch_ok;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pci_fwd_decoder i_pci_fwd_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .txn_valid(txn_valid), .txn_addr(txn_addr), .txn_cmd(txn_cmd),
    .txn_from_sec(txn_from_sec), .txn_vga_hit(txn_vga_hit), .dec_valid(dec_valid),
    .fwd_down(fwd_down), .fwd_up(fwd_up), .prefetch_ok(prefetch_ok)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic send(input string req, input logic sec, input logic vga,
                      input logic [2:0] cmd, input logic [31:0] a, input logic [2:0] exp);
    @(negedge clk);
    txn_valid = 1'b1; txn_from_sec = sec; txn_vga_hit = vga; txn_cmd = cmd; txn_addr = a;
    @(negedge clk);
    txn_valid = 1'b0;
    check(req, {dec_valid, fwd_down, fwd_up, prefetch_ok}, {1'b1, exp});
  endtask

  task automatic base_windows();
    cfg_write(2'd1, 32'h0003_0001);   // I/O 0x1000..0x3FFF
    cfg_write(2'd2, 32'h01FF_0100);   // 0x1000_0000..0x1FFF_FFFF
    cfg_write(2'd3, 32'h04FF_0400);   // 0x4000_0000..0x4FFF_FFFF
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 outputs in reset", {dec_valid, fwd_down, fwd_up, prefetch_ok}, 4'b0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 outputs after reset", {dec_valid, fwd_down, fwd_up, prefetch_ok}, 4'b0000);
    send("R2 enables clear after reset", 1'b1, 1'b0, MRD, 32'h2000_0000, 3'b000);
    cfg_write(2'd0, 32'h7);
    send("R2 I/O window empty", 1'b0, 1'b0, IORD, 32'h0000_0000, 3'b000);
    send("R2 I/O empty goes up", 1'b1, 1'b0, IORD, 32'h0000_0000, 3'b010);
    send("R2 mem windows empty", 1'b0, 1'b0, MRD, 32'hFFF0_0000, 3'b000);

    base_windows();
    for (int i = 0; i < NV; i++)
      send($sformatf("vector %0d", i), VEC[i][39], VEC[i][38], VEC[i][37:35],
           VEC[i][34:3], VEC[i][2:0]);

    @(negedge clk);
    check("R1 no strobe no decision", {dec_valid, fwd_down, fwd_up, prefetch_ok}, 4'b0000);

    for (int c = 0; c < 8; c++) begin
      logic [2:0] e = 3'(c);
      cfg_write(2'd0, {29'd0, e});
      send("R6 mem enable gates down", 1'b0, 1'b0, MRD, 32'h1000_0000, {e[1], 2'b00});
      send("R7 master gates mem up", 1'b1, 1'b0, MRD, 32'h2000_0000, {1'b0, e[2], 1'b0});
      send("R7 master gates I/O up", 1'b1, 1'b0, IORD, 32'h0000_1100,
           {1'b0, e[2] & e[0], 1'b0});
      send("R4 alias gates I/O down", 1'b0, 1'b0, IORD, 32'h0000_1100, {~e[0], 2'b00});
      send("R6 I/O down ignores mem enable", 1'b0, 1'b0, IORD, 32'h0000_2000, 3'b100);
    end

    cfg_write(2'd0, 32'h7);
    cfg_write(2'd1, 32'h0003_0004);
    send("R3 base above limit disables", 1'b0, 1'b0, IORD, 32'h0000_3000, 3'b000);
    send("R3 disabled window goes up", 1'b1, 1'b0, IORD, 32'h0000_3000, 3'b010);
    cfg_write(2'd3, 32'h0000_0FFF);
    send("R11 pref window reloaded empty", 1'b1, 1'b0, MWR, 32'h4000_0000, 3'b010);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule